// File: doc/BRIEF.md
# Edge-Counting Interval Measurement Controller

This block measures the time between two events by counting every transition, both rising and falling, of a measurement clock input. A host issues 2-bit commands to arm a measurement, abort it or clear its results. Once the start condition is seen, the engine counts clock transitions until a qualified stop event arrives. The count is then frozen and the done flag is raised. Each of the start and stop inputs has its own active level. An optional skip counter lets the engine pass over a programmed number of stop events, which is useful when averaging over several periods of a signal. A programmable saturation point ends a measurement that runs too long.

Two arming modes exist. Level arming begins counting as soon as start is at its active level. Edge-qualified arming first requires start to leave its active level and then begins on the next return to it. Start, stop and the measurement clock are asynchronous, so each passes through a two-stage synchronizer. Clock transitions are detected in the system clock domain as value changes of the synchronized copy. Commands arrive as a single-cycle strobe with no back-pressure: the block samples a command on every cycle in which `cmd_valid` is high, and there is no ready signal.

Top module: `tdc_meas_ctrl`

## Requirements
- R1: After reset, `state_code` is 0x06 (idle), `done` and `saturated` are 0 and `result` is 0.
- R2: Command code 2 (level arming), issued in idle, moves to state 0x00. Counting starts (state 0x08) once start is at its active level, including when start is already active at the time of the command.
- R3: Command code 1 (edge-qualified arming), issued in idle, moves to state 0x1E. The state stays there while start holds its active level. Once start goes inactive, the state becomes 0x00, and counting starts on the next return to the active level. Clock transitions before that point are not counted.
- R4: In state 0x08, `result` increases by one for each rising transition and for each falling transition of `meas_clk_in`.
- R5: In state 0x08, a stop event is a change of stop from inactive to active. A stop event that ends the measurement freezes `result`, sets `done`, passes through state 0x0E for one cycle and returns to 0x06.
- R6: `start_low` = 1 makes start active when low, and 0 makes it active when high. `stop_low` selects the stop level the same way.
- R7: With `skip_en` = 1, the skip counter is loaded from `skip_load` when counting starts. The first load-minus-one stop events are ignored, and the measurement ends on event number load. A load value of 0 acts as 1.
- R8: Saturation code c, for c from 3 to 15, selects result bit c+9. When that bit becomes set, counting stops with `result` exactly 2^(c+9), the state passes through 0x2E for one cycle, and both `saturated` and `done` are set.
- R9: Command code 3 (abort) returns the engine to 0x06 from any state. An aborted measurement leaves `done` at 0.
- R10: Command code 0 (clear), issued in idle, sets `result`, `done` and `saturated` to 0.
- R11: Accepting an arming command (code 1 or 2) in idle clears `result`, `done` and `saturated`.
- R12: Outside idle, all commands other than abort are ignored. The state and the running count are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 2 | 0 clear, 1 edge-qualified arm, 2 level arm, 3 abort |
| start_in | input | 1 | Asynchronous start signal |
| stop_in | input | 1 | Asynchronous stop signal |
| meas_clk_in | input | 1 | Measurement clock whose transitions are counted |
| start_low | input | 1 | 1: start active low, 0: active high |
| stop_low | input | 1 | 1: stop active low, 0: active high |
| skip_en | input | 1 | Enables the stop-event skip counter |
| skip_load | input | 16 | Stop event number that ends the measurement |
| sat_code | input | 4 | Saturation bit selector (bit = code + 9) |
| state_code | output | 6 | Engine state code |
| done | output | 1 | Measurement complete |
| saturated | output | 1 | Measurement ended by saturation |
| result | output | 25 | Number of counted clock transitions |

## Verification
The bench aims at the edge-qualified arm. It holds start active across the command and toggles the clock while waiting. A design that armed on level would leave state 0x1E early and count those toggles. Saturation is driven past the selected bit at the smallest code. A counter that did not freeze would report more than 4096, and a wrong bit mapping would stop at a different count. The skip counter is tested with load 3 and with load 0. Mishandling either case would end the measurement one event early or late. Arming and clear commands are issued in the middle of a measurement. A design that accepted them would reset the count or the state.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    CMD_CLEAR = 2'd0,
    CMD_SYNC  = 2'd1,
    CMD_RUN   = 2'd2,
    CMD_ABORT = 2'd3
  } tdc_cmd_e;

  // state codes are visible at the port and decoded by software
  typedef enum logic [5:0] {
    ST_WSTART = 6'h00,
    ST_IDLE   = 6'h06,
    ST_COUNT  = 6'h08,
    ST_FREEZE = 6'h0E,
    ST_WFALL  = 6'h1E,
    ST_FORCED = 6'h2E
  } tdc_state_e;
endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tdc_edge_counter.sv
module tdc_edge_counter #(
  parameter int RES_W        = 25,
  parameter int SAT_CODE_W   = 4,
  parameter int SAT_MIN_CODE = 3,
  parameter int SAT_BASE_BIT = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  run,
  input  logic                  mclk_evt,
  input  logic [SAT_CODE_W-1:0] sat_code,
  output logic [RES_W-1:0]      count,
  output logic                  sat_hit
);
  localparam int IDX_W = $clog2(RES_W);

  logic [IDX_W-1:0] sat_idx;
  int               idx_calc;

  always_comb begin
    idx_calc = int'(sat_code) - SAT_MIN_CODE + SAT_BASE_BIT;
    if (int'(sat_code) < SAT_MIN_CODE || idx_calc > RES_W - 1) idx_calc = RES_W - 1;
    sat_idx = IDX_W'(idx_calc);
  end

  assign sat_hit = count[sat_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           count <= '0;
    else if (clr)                         count <= '0;
    else if (run && mclk_evt && !sat_hit) count <= count + 1'b1;
  end

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  p_freeze_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !clr) |=> $stable(count));
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count) || count == $past(count) + 1'b1));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));
endmodule

// File: rtl/tdc_ctrl_fsm.sv
module tdc_ctrl_fsm
  import tdc_pkg::*;
#(
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              start_act,
  input  logic              stop_act,
  input  logic              sat_hit,
  input  logic              skip_en,
  input  logic [SKIP_W-1:0] skip_load,
  output tdc_state_e        state,
  output logic              count_run,
  output logic              clr_result,
  output logic              done,
  output logic              saturated
);
  logic              start_prev, stop_prev;
  logic [SKIP_W-1:0] skip_cnt;
  logic              is_abort, start_fall, stop_evt, in_idle;
  tdc_cmd_e          cmd;

  assign cmd        = tdc_cmd_e'(cmd_code);
  assign in_idle    = (state == ST_IDLE);
  assign is_abort   = cmd_valid && (cmd == CMD_ABORT);
  assign clr_result = cmd_valid && in_idle && (cmd != CMD_ABORT);
  assign start_fall = start_prev && !start_act;
  assign stop_evt   = stop_act && !stop_prev;
  assign count_run  = (state == ST_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      start_prev <= 1'b0;
      stop_prev  <= 1'b0;
      skip_cnt   <= '0;
      done       <= 1'b0;
      saturated  <= 1'b0;
    end else begin
      start_prev <= start_act;
      stop_prev  <= stop_act;
      if (clr_result) begin
        done      <= 1'b0;
        saturated <= 1'b0;
      end
      if (is_abort) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (cmd_valid && cmd == CMD_RUN)       state <= ST_WSTART;
            else if (cmd_valid && cmd == CMD_SYNC) state <= ST_WFALL;
          end
          ST_WFALL:  if (start_fall) state <= ST_WSTART;
          ST_WSTART: begin
            if (start_act) begin
              state    <= ST_COUNT;
              skip_cnt <= (skip_load == '0) ? SKIP_W'(1) : skip_load;
            end
          end
          ST_COUNT: begin
            if (sat_hit) begin
              state     <= ST_FORCED;
              done      <= 1'b1;
              saturated <= 1'b1;
            end else if (stop_evt) begin
              if (!skip_en || skip_cnt <= SKIP_W'(1)) begin
                state <= ST_FREEZE;
                done  <= 1'b1;
              end else begin
                skip_cnt <= skip_cnt - 1'b1;
              end
            end
          end
          ST_FREEZE: state <= ST_IDLE;
          ST_FORCED: state <= ST_IDLE;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_abort |=> state == ST_IDLE);
  p_abort_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_abort && !in_idle && !done) |=> !done);
  p_freeze_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FREEZE) |=> (state == ST_IDLE && done));
  p_forced_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FORCED) |=> (state == ST_IDLE && saturated && done));
  p_arm_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cmd_valid && (cmd == CMD_RUN || cmd == CMD_SYNC)) |=> (!done && !saturated));
  p_skip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_run && stop_evt && skip_en && skip_cnt > SKIP_W'(1) && !sat_hit && !is_abort)
      |=> state == ST_COUNT);
  p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WFALL && cmd_valid && !is_abort && !start_fall) |=> state == ST_WFALL);
endmodule

// File: rtl/tdc_meas_ctrl.sv
module tdc_meas_ctrl
  import tdc_pkg::*;
#(
  parameter int RES_W        = 25,
  parameter int SKIP_W       = 16,
  parameter int SAT_CODE_W   = 4,
  parameter int SAT_MIN_CODE = 3,
  parameter int SAT_BASE_BIT = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_code,
  input  logic                  start_in,
  input  logic                  stop_in,
  input  logic                  meas_clk_in,
  input  logic                  start_low,
  input  logic                  stop_low,
  input  logic                  skip_en,
  input  logic [SKIP_W-1:0]     skip_load,
  input  logic [SAT_CODE_W-1:0] sat_code,
  output logic [5:0]            state_code,
  output logic                  done,
  output logic                  saturated,
  output logic [RES_W-1:0]      result
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw_in, synced;
  logic            mclk_prev, mclk_evt;
  logic            start_act, stop_act;
  logic            count_run, clr_result, sat_hit;
  tdc_state_e      state;

  assign raw_in = {meas_clk_in, stop_in, start_in};

  tdc_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclk_prev <= 1'b0;
    else        mclk_prev <= synced[2];
  end

  assign mclk_evt  = synced[2] ^ mclk_prev;
  assign start_act = synced[0] ^ start_low;
  assign stop_act  = synced[1] ^ stop_low;

  tdc_ctrl_fsm #(.SKIP_W(SKIP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .start_act(start_act), .stop_act(stop_act), .sat_hit(sat_hit),
    .skip_en(skip_en), .skip_load(skip_load), .state(state),
    .count_run(count_run), .clr_result(clr_result), .done(done),
    .saturated(saturated)
  );

  tdc_edge_counter #(
    .RES_W(RES_W), .SAT_CODE_W(SAT_CODE_W),
    .SAT_MIN_CODE(SAT_MIN_CODE), .SAT_BASE_BIT(SAT_BASE_BIT)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_result), .run(count_run),
    .mclk_evt(mclk_evt), .sat_code(sat_code), .count(result), .sat_hit(sat_hit)
  );

  assign state_code = state;

  p_done_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (state == ST_FREEZE || state == ST_FORCED));
  p_count_only_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result) && $past(!clr_result)) |-> $past(count_run));
endmodule

// File: tb/sim_tdc_meas_ctrl.sv
module sim_tdc_meas_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_code = 0;
  logic        start_in = 0, stop_in = 0, meas_clk_in = 0;
  logic        start_low = 0, stop_low = 0, skip_en = 0;
  logic [15:0] skip_load = 0;
  logic [3:0]  sat_code = 4'd15;
  logic [5:0]  state_code;
  logic        done, saturated;
  logic [24:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  tdc_meas_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .start_in(start_in), .stop_in(stop_in), .meas_clk_in(meas_clk_in),
    .start_low(start_low), .stop_low(stop_low), .skip_en(skip_en),
    .skip_load(skip_load), .sat_code(sat_code), .state_code(state_code),
    .done(done), .saturated(saturated), .result(result)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      meas_clk_in = ~meas_clk_in;
      cyc(3);
    end
  endtask

  task automatic pulse_stop();
    stop_in = ~stop_low; cyc(4);
    stop_in = stop_low;  cyc(4);
  endtask

  task automatic t_reset();
    chk("R1", "state", state_code, 6'h06);
    chk("R1", "done", done, 0);
    chk("R1", "sat", saturated, 0);
    chk("R1", "result", result, 0);
  endtask

  task automatic t_level_run();
    start_in = 0; stop_in = 0;
    send(2'd2); cyc(2);
    chk("R2", "wait start", state_code, 6'h00);
    start_in = 1; cyc(6);
    chk("R2", "counting", state_code, 6'h08);
    toggle(7); cyc(4);
    chk("R4", "count both edges", result, 7);
    pulse_stop();
    chk("R5", "frozen", result, 7);
    chk("R5", "done", done, 1);
    chk("R5", "idle", state_code, 6'h06);
    toggle(2);
    chk("R5", "no count in idle", result, 7);
    start_in = 0; cyc(4);
  endtask

  task automatic t_already_active();
    start_in = 1; cyc(5);
    send(2'd2); cyc(4);
    chk("R2", "start already active", state_code, 6'h08);
    chk("R11", "arm clears done", done, 0);
    chk("R11", "arm clears result", result, 0);
    toggle(3); pulse_stop();
    chk("R2", "result", result, 3);
    start_in = 0; cyc(4);
  endtask

  task automatic t_sync_run();
    start_in = 1; cyc(5);
    send(2'd1); cyc(4);
    chk("R3", "wait fall", state_code, 6'h1E);
    toggle(2);
    chk("R3", "still wait fall", state_code, 6'h1E);
    start_in = 0; cyc(5);
    chk("R3", "after fall", state_code, 6'h00);
    toggle(2);
    start_in = 1; cyc(5);
    chk("R3", "counting", state_code, 6'h08);
    toggle(5); pulse_stop();
    chk("R3", "result", result, 5);
    chk("R3", "done", done, 1);
    start_in = 0; cyc(4);
  endtask

  task automatic t_polarity();
    start_low = 1; stop_low = 1; start_in = 1; stop_in = 1; cyc(6);
    send(2'd2); cyc(5);
    chk("R6", "low start not yet", state_code, 6'h00);
    start_in = 0; cyc(5);
    chk("R6", "low start active", state_code, 6'h08);
    toggle(3); pulse_stop();
    chk("R6", "low stop result", result, 3);
    chk("R6", "idle", state_code, 6'h06);
    start_in = 1; cyc(4);
    start_low = 0; stop_low = 0; start_in = 0; stop_in = 0; cyc(6);
  endtask

  task automatic t_skip();
    skip_en = 1; skip_load = 16'd3;
    send(2'd2); start_in = 1; cyc(6);
    toggle(2); pulse_stop(); pulse_stop();
    chk("R7", "two events skipped", state_code, 6'h08);
    toggle(2); pulse_stop();
    chk("R7", "third event stops", state_code, 6'h06);
    chk("R7", "result", result, 4);
    start_in = 0; cyc(4);
    skip_load = 16'd0;
    send(2'd2); start_in = 1; cyc(6);
    toggle(1); pulse_stop();
    chk("R7", "load 0 stops first", state_code, 6'h06);
    chk("R7", "load 0 result", result, 1);
    skip_en = 0; start_in = 0; cyc(4);
  endtask

  task automatic t_busy_ignore();
    send(2'd2); start_in = 1; cyc(6);
    toggle(4);
    send(2'd0); send(2'd1); send(2'd2); cyc(2);
    chk("R12", "state kept", state_code, 6'h08);
    chk("R12", "count kept", result, 4);
    toggle(2); pulse_stop();
    chk("R12", "final", result, 6);
    start_in = 0; cyc(4);
  endtask

  task automatic t_clear();
    chk("R10", "pre done", done, 1);
    send(2'd0); cyc(2);
    chk("R10", "result", result, 0);
    chk("R10", "done", done, 0);
    chk("R10", "state", state_code, 6'h06);
  endtask

  task automatic t_abort();
    send(2'd2); start_in = 1; cyc(6);
    toggle(3);
    send(2'd3); cyc(2);
    chk("R9", "abort idle", state_code, 6'h06);
    chk("R9", "abort no done", done, 0);
    start_in = 0; cyc(4);
    send(2'd1); cyc(3);
    send(2'd3); cyc(2);
    chk("R9", "abort from wait fall", state_code, 6'h06);
  endtask

  task automatic t_saturate();
    bit seen_forced = 0;
    sat_code = 4'd3;
    send(2'd2); start_in = 1; cyc(6);
    toggle(4095); cyc(4);
    chk("R8", "below limit", state_code, 6'h08);
    meas_clk_in = ~meas_clk_in;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      if (state_code == 6'h2E) seen_forced = 1;
    end
    chk("R8", "forced state seen", seen_forced, 1);
    toggle(4);
    chk("R8", "result", result, 4096);
    chk("R8", "sat flag", saturated, 1);
    chk("R8", "done", done, 1);
    chk("R8", "idle", state_code, 6'h06);
    start_in = 0; cyc(4);
    send(2'd2); cyc(2);
    chk("R11", "arm clears sat", saturated, 0);
    chk("R11", "arm clears result", result, 0);
    send(2'd3); sat_code = 4'd15; cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_level_run();
    t_already_active();
    t_sync_run();
    t_polarity();
    t_skip();
    t_busy_ignore();
    t_clear();
    t_abort();
    t_saturate();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule